// File: doc/BRIEF.md
# Prioritised Interrupt Status and Mask Controller

This block gathers level-sensitive interrupt requests from thirteen peripheral sources into a 32-bit pending-status word. Each source owns one fixed bit of that word. A 32-bit enable mask sits beside it. Each source bit belongs to one of three fixed priority groups, with levels 3, 5 and 6. The block drives a 3-bit processor priority level. That level is the highest group that has at least one bit that is both pending and enabled.

Software reads and writes both words in full through a simple 32-bit register port. The status word is at offset 0x7000 and the mask word is at offset 0x7800. Two side inputs let neighbouring blocks change single status bits directly. One is the storage-controller control-byte write, which sets or clears the SCSI DMA bit. The other is a clear strobe from the clock chip, which drops the power bit. Vector acknowledge and autovector generation are left to the processor interface.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the status word and the mask word both read 0, and the priority level output is 0.
- R2: A rising source request sets its status bit at the first clock edge after the rise. The request vector index maps to status bits as follows: 0→7, 1→3, 2→2, 3→9, 4→10, 5→12, 6→5, 7→17, 8→28, 9→27, 10→26, 11→23, 12→21.
- R3: A falling source request clears its status bit at the first clock edge after the fall. A request that holds steady leaves a software-written value alone.
- R4: A bus write with select and write high stores all 32 bits of write data. It goes to the status word when the address is 0x7000 and to the mask word when the address is 0x7800. A read at either address returns that word. A read at any other address returns 0. A write to any other address changes neither word.
- R5: The level output is 6 when a bit of mask 0x1CA00000 is both pending and enabled. Otherwise it is 5 when bit 17 is both pending and enabled. Otherwise it is 3 when a bit of mask 0x000016AC is both pending and enabled. Otherwise it is 0. The level follows a register change in the same cycle.
- R6: The mask is an active-high enable. A pending bit whose mask bit is 0 does not raise the level.
- R7: A control-byte strobe with data bit 4 set sets status bit 26. The same strobe with data bit 4 clear clears status bit 26.
- R8: A clock-chip clear strobe clears status bit 2 at the next edge.
- R9: When a hardware set or clear lands in the same cycle as a software write to the status word, the hardware update decides the bits it touches. All other bits take the written value.
- R10: When a set and a clear from hardware hit the same bit in the same cycle, the set wins.
- R11: Status bits outside the three groups can be written and read back, but they never change the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 13 | Level-sensitive source request lines, indexed as in R2 |
| ctl_wr | input | 1 | Strobe for a storage-controller control-byte write |
| ctl_data | input | 8 | Control byte; bit 4 selects set or clear of the SCSI DMA bit |
| rtc_clr | input | 1 | Clock-chip strobe that clears the power status bit |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 16 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read access |
| irq_level | output | 3 | Processor priority level: 0, 3, 5 or 6 |

## Verification
A table drives status and mask pairs and checks the level for each pair. The pairs show a single group on its own, and two or three groups pending together, where the highest group has to win. They show pending bits that are masked off, which must leave the level low, and bits outside any group. Each source line is then raised and lowered in turn. This shows that its bit lands in the right position and leaves the other bits unchanged. Collisions are driven on purpose. These are a source edge against a software write, a clock-chip clear against a write, and a control-byte clear against a DMA source rise. Each collision shows which writer owns the contested bit.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int REG_W = 32;
    localparam int N_SRC = 13;
    localparam int N_GRP = 3;
    localparam int LVL_W = 3;

    localparam int SCSI_DMA_BIT = 26;
    localparam int PWR_BIT      = 2;
    localparam int CTL_DMA_POS  = 4;

    typedef logic [REG_W-1:0] word_t;

    // Status bit owned by each request index.
    function automatic int src_bit(input int idx);
        case (idx)
            0:       return 7;
            1:       return 3;
            2:       return 2;
            3:       return 9;
            4:       return 10;
            5:       return 12;
            6:       return 5;
            7:       return 17;
            8:       return 28;
            9:       return 27;
            10:      return 26;
            11:      return 23;
            default: return 21;
        endcase
    endfunction

    // Priority group of each request index: 0 lowest, N_GRP-1 highest.
    function automatic int src_grp(input int idx);
        if (idx < 7)       return 0;
        else if (idx == 7) return 1;
        else               return 2;
    endfunction

    function automatic logic [LVL_W-1:0] grp_level(input int g);
        case (g)
            0:       return LVL_W'(3);
            1:       return LVL_W'(5);
            default: return LVL_W'(6);
        endcase
    endfunction

    // Status bits that belong to group g, built from the source tables.
    function automatic word_t grp_bits(input int g);
        word_t m;
        m = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (src_grp(i) == g) m[src_bit(i)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_src_edge.sv
module irq_src_edge
    import irq_prio_pkg::*;
#(
    parameter int NSRC = N_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            ctl_wr,
    input  logic [7:0]      ctl_data,
    input  logic            rtc_clr,
    output word_t           hw_set,
    output word_t           hw_clr
);

    typedef struct packed {
        logic [NSRC-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    word_t       set_d, clr_d;

    always_comb begin
        st_d.prev = src_req;
        set_d     = '0;
        clr_d     = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (src_req[i] && !st_q.prev[i]) set_d[src_bit(i)] = 1'b1;
            if (!src_req[i] && st_q.prev[i]) clr_d[src_bit(i)] = 1'b1;
        end
        if (ctl_wr) begin
            if (ctl_data[CTL_DMA_POS]) set_d[SCSI_DMA_BIT] = 1'b1;
            else                       clr_d[SCSI_DMA_BIT] = 1'b1;
        end
        if (rtc_clr) clr_d[PWR_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hw_set = set_d;
    assign hw_clr = clr_d;

    AST_CTL_SETS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_data[CTL_DMA_POS] |-> hw_set[SCSI_DMA_BIT]); // R7

    AST_RTC_CLEARS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_clr |-> hw_clr[PWR_BIT]); // R8

endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import irq_prio_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 16'h7000,
    parameter logic [ADDR_W-1:0] MASK_OFS   = 16'h7800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  word_t             bus_wdata,
    output word_t             bus_rdata,
    input  word_t             hw_set,
    input  word_t             hw_clr,
    output word_t             status,
    output word_t             mask
);

    typedef struct packed {
        word_t status;
        word_t mask;
    } reg_state_t;

    reg_state_t rs_d, rs_q;
    logic       wr_status, wr_mask;

    always_comb begin
        wr_status = bus_sel && bus_wr && (bus_addr == STATUS_OFS);
        wr_mask   = bus_sel && bus_wr && (bus_addr == MASK_OFS);
        rs_d      = rs_q;
        if (wr_status) rs_d.status = bus_wdata;
        if (wr_mask)   rs_d.mask   = bus_wdata;
        // hardware overrides software; set overrides clear
        rs_d.status = (rs_d.status & ~hw_clr) | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == STATUS_OFS)    bus_rdata = rs_q.status;
            else if (bus_addr == MASK_OFS) bus_rdata = rs_q.mask;
        end
    end

    assign status = rs_q.status;
    assign mask   = rs_q.mask;

    AST_HW_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((rs_q.status & $past(hw_set)) == $past(hw_set))); // R10

    AST_HW_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_clr & ~hw_set) != '0) |=> ((rs_q.status & $past(hw_clr & ~hw_set)) == '0)); // R9

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_wr && (bus_addr == MASK_OFS) |=> rs_q.mask == $past(bus_wdata)); // R4

    AST_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_wr && (bus_addr == STATUS_OFS) && hw_set == '0 && hw_clr == '0
        |=> rs_q.status == $past(bus_wdata)); // R4

endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
    import irq_prio_pkg::*;
(
    input  word_t            status,
    input  word_t            mask,
    output logic [LVL_W-1:0] level
);

    word_t            pending;
    logic [N_GRP-1:0] grp_hit;

    assign pending = status & mask;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam word_t GBITS = grp_bits(g);
        assign grp_hit[g] = |(pending & GBITS);
    end

    always_comb begin
        level = '0;
        for (int g = 0; g < N_GRP; g++) begin
            if (grp_hit[g]) level = grp_level(g);
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 16'h7000,
    parameter logic [ADDR_W-1:0] MASK_OFS   = 16'h7800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_data,
    input  logic              rtc_clr,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [LVL_W-1:0]  irq_level
);

    localparam word_t ALL_GRP = grp_bits(0) | grp_bits(1) | grp_bits(2);

    word_t hw_set, hw_clr, status, mask;

    irq_src_edge #(.NSRC(N_SRC)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .ctl_wr   (ctl_wr),
        .ctl_data (ctl_data),
        .rtc_clr  (rtc_clr),
        .hw_set   (hw_set),
        .hw_clr   (hw_clr)
    );

    irq_status_regs #(
        .ADDR_W     (ADDR_W),
        .STATUS_OFS (STATUS_OFS),
        .MASK_OFS   (MASK_OFS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hw_set    (hw_set),
        .hw_clr    (hw_clr),
        .status    (status),
        .mask      (mask)
    );

    irq_level_enc u_enc (
        .status (status),
        .mask   (mask),
        .level  (irq_level)
    );

    AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level == 3'd0 || irq_level == 3'd3 || irq_level == 3'd5 || irq_level == 3'd6); // R5

    AST_IDLE_WHEN_NOTHING_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & mask & ALL_GRP) == '0) |-> irq_level == 3'd0); // R6

endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] src_req = '0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_data = '0;
    logic        rtc_clr = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_level;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .ctl_wr(ctl_wr),
        .ctl_data(ctl_data), .rtc_clr(rtc_clr), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_level(irq_level)
    );

    localparam logic [15:0] A_ST = 16'h7000;
    localparam logic [15:0] A_MK = 16'h7800;
    localparam logic [31:0] G3 = 32'h0000_16AC;
    localparam logic [31:0] G5 = 32'h0002_0000;
    localparam logic [31:0] G6 = 32'h1CA0_0000;

    localparam int NV = 10;
    localparam logic [31:0] V_ST [NV] = '{32'h0000_0080, 32'h0002_0000, 32'h0400_0000,
        32'h0402_0004, 32'h0002_1000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0080_0020,
        32'h1000_0008, 32'h4000_0000};
    localparam logic [31:0] V_MK [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0020,
        32'h0000_0008, 32'hFFFF_FFFF};
    localparam logic [2:0] V_LV [NV] = '{3'd3, 3'd5, 3'd6, 3'd6, 3'd5, 3'd0, 3'd0,
        3'd3, 3'd3, 3'd0};

    function automatic int bit_of(input int idx);
        int t [13] = '{7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 23, 21};
        return t[idx];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(A_ST, r); check("R1 status", r, 0);
        rd(A_MK, r); check("R1 mask", r, 0);
        check("R1 level", {29'd0, irq_level}, 0);
        rst_n = 1;
        @(negedge clk);

        // R5 R6 R11 vector table
        for (int i = 0; i < NV; i++) begin
            wr(A_ST, V_ST[i]);
            wr(A_MK, V_MK[i]);
            check("R5/R6/R11 level", {29'd0, irq_level}, {29'd0, V_LV[i]});
        end
        rd(A_ST, r); check("R11 readback", r, 32'h4000_0000);
        rd(A_MK, r); check("R4 mask readback", r, 32'hFFFF_FFFF);

        // R4 other addresses
        wr(16'h7004, 32'h1234_5678);
        rd(A_ST, r); check("R4 stray write status", r, 32'h4000_0000);
        rd(16'h7004, r); check("R4 stray read", r, 0);

        // R2 R3 each source
        wr(A_ST, 0);
        for (int i = 0; i < 13; i++) begin
            @(negedge clk); src_req[i] = 1;
            @(negedge clk);
            rd(A_ST, r); check("R2 source sets bit", r, 32'(1) << bit_of(i));
            src_req[i] = 0;
            @(negedge clk);
            rd(A_ST, r); check("R3 source clears bit", r, 0);
        end

        // R3 steady request leaves software value
        @(negedge clk); src_req[1] = 1;
        @(negedge clk);
        wr(A_ST, 32'h0000_0100);
        @(negedge clk);
        rd(A_ST, r); check("R3 steady request", r, 32'h0000_0100);
        src_req[1] = 0;
        @(negedge clk);

        // R7 control byte set/clear
        wr(A_ST, 0);
        ctl_wr = 1; ctl_data = 8'h10;
        @(negedge clk); ctl_wr = 0;
        rd(A_ST, r); check("R7 set bit26", r, 32'h0400_0000);
        check("R7 level", {29'd0, irq_level}, 6);
        ctl_wr = 1; ctl_data = 8'hEF;
        @(negedge clk); ctl_wr = 0;
        rd(A_ST, r); check("R7 clear bit26", r, 0);

        // R8 clock-chip clear
        wr(A_ST, 32'h0000_0024);
        rtc_clr = 1;
        @(negedge clk); rtc_clr = 0;
        rd(A_ST, r); check("R8 clear bit2", r, 32'h0000_0020);

        // R9 source rise collides with status write
        bus_sel = 1; bus_wr = 1; bus_addr = A_ST; bus_wdata = 32'h0000_0008;
        src_req[0] = 1;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
        rd(A_ST, r); check("R9 set vs write", r, 32'h0000_0088);
        // R9 clock-chip clear collides with status write
        bus_sel = 1; bus_wr = 1; bus_addr = A_ST; bus_wdata = 32'h0000_0006;
        rtc_clr = 1;
        @(negedge clk); bus_sel = 0; bus_wr = 0; rtc_clr = 0;
        rd(A_ST, r); check("R9 clear vs write", r, 32'h0000_0002);

        // R10 set beats clear on bit 26
        wr(A_ST, 0);
        src_req[10] = 1; ctl_wr = 1; ctl_data = 8'h00;
        @(negedge clk); ctl_wr = 0;
        rd(A_ST, r); check("R10 set wins", r, 32'h0400_0000);

        // R1 reset mid-run
        rst_n = 0;
        @(negedge clk);
        rd(A_ST, r); check("R1 status after reset", r, 0);
        check("R1 level after reset", {29'd0, irq_level}, 0);

        finish_run();
    end

endmodule